// File: doc/BRIEF.md
# Pipe Buffer-Not-Ready Interrupt Status Register

This block holds seven sticky "buffer not ready" flags for a peripheral with one default control pipe and six numbered data pipes. Each pipe raises a single-cycle event pulse when its buffer is not ready. The pulse latches the pipe's flag, and the flag stays set until the host clears it. The host sees the flags as one 16-bit register at byte offset 0x68 of a synchronous register bus. Reads need no wait states.

Clearing works in the reverse of the common write-one-to-clear scheme. The host writes a 0 to each flag it wants cleared and a 1 to each flag it wants left alone. A single write can therefore acknowledge exactly the flags it has already handled. A combined interrupt request is raised while any flag is set and its matching enable input is high. Hardware reset and software reset both clear every flag. A bus-reset indication leaves the flags untouched.

Top module: `nrdy_irq_status`

## Requirements
- R1: A one-cycle pulse on `evt_i[k]` sets flag k at the next rising clock edge, and the flag stays set after the pulse ends.
- R2: A write to address 0x68 clears every flag whose data bit (bits 6..0) is 0. Flags whose data bit is 1 keep their value.
- R3: A read of address 0x68 returns the control-pipe flag in bit 0 and the flag of pipe k (k = 1..6) in bit k, each reading 1 when set. Bits 15..7 read 0.
- R4: A read of any address other than 0x68 returns 0x0000, and a write to any other address leaves all flags unchanged.
- R5: When an event pulse and a write-0 clear reach the same flag in the same cycle, the flag ends up set.
- R6: Asserting `hw_rst_n` low clears all flags at once, so the register reads 0x0000.
- R7: When `sw_rst` is high at a rising edge, every flag is 0 after that edge, even if an event arrives in the same cycle.
- R8: Pulsing `bus_rst` changes no flag.
- R9: `irq_o` is high exactly while, for some k, flag k and `irq_en_i[k]` are both 1. It follows changes of `irq_en_i` in the same cycle.
- R10: Ones written to bits 15..7 are ignored: those bits still read 0 and no flag changes because of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and flag clock |
| hw_rst_n | input | 1 | Asynchronous hardware reset, active low |
| sw_rst | input | 1 | Synchronous software reset, active high |
| bus_rst | input | 1 | Bus-reset indication; has no effect on the flags |
| evt_i | input | 7 | Not-ready event pulses; bit 0 is the control pipe, bit k is pipe k |
| irq_en_i | input | 7 | Per-flag interrupt enables |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data; a 0 in bits 6..0 clears the matching flag |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach is a write-0 clear that lands in the same clock cycle as an event pulse on the same flag. A bench that drives the two from separate tasks at different times will never produce it. The stimulus table therefore puts the event and the clearing write into one vector, applied at the same falling edge, so that a single rising edge sees both. Directed tests then line up a software reset with a full set of event pulses, and a bus-reset pulse with all flags set, to confirm which reset wins and that the bus reset leaves the flags alone.

// File: rtl/nrdy_pkg.sv
package nrdy_pkg;
   localparam int unsigned NRDY_DEF_PIPES  = 7;
   localparam int unsigned NRDY_DEF_DATA_W = 16;
   localparam int unsigned NRDY_DEF_ADDR_W = 8;
   localparam logic [7:0]  NRDY_DEF_OFFSET = 8'h68;

   typedef enum logic [0:0] {
      PRIO_CLEAR_WINS = 1'b0,
      PRIO_EVENT_WINS = 1'b1
   } nrdy_prio_e;

   typedef struct packed {
      logic set;
      logic clr;
   } nrdy_flag_req_t;
endpackage

// File: rtl/nrdy_flag_cell.sv
module nrdy_flag_cell
   import nrdy_pkg::*;
#(
   parameter nrdy_prio_e PRIO = PRIO_EVENT_WINS
) (
   input  logic           clk,
   input  logic           hw_rst_n,
   input  logic           sw_rst,
   input  nrdy_flag_req_t req,
   output logic           flag_q
);
   logic flag_d;

   generate
      if (PRIO == PRIO_EVENT_WINS) begin : g_evt_first
         always_comb begin
            if (req.set)      flag_d = 1'b1;
            else if (req.clr) flag_d = 1'b0;
            else              flag_d = flag_q;
         end
      end else begin : g_clr_first
         always_comb begin
            if (req.clr)      flag_d = 1'b0;
            else if (req.set) flag_d = 1'b1;
            else              flag_d = flag_q;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge hw_rst_n) begin
      if (!hw_rst_n)   flag_q <= 1'b0;
      else if (sw_rst) flag_q <= 1'b0;
      else             flag_q <= flag_d;
   end
endmodule

// File: rtl/nrdy_reg_decode.sv
module nrdy_reg_decode #(
   parameter int unsigned NUM_FLAGS = 7,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h68
) (
   input  logic [ADDR_W-1:0]    addr,
   input  logic                 we,
   input  logic [DATA_W-1:0]    wdata,
   input  logic [NUM_FLAGS-1:0] flags,
   output logic [NUM_FLAGS-1:0] clr_req,
   output logic [DATA_W-1:0]    rdata
);
   localparam int unsigned RSVD_W = DATA_W - NUM_FLAGS;

   logic hit;
   logic unused_rsvd_wdata;

   assign hit = (addr == REG_OFFSET);

   generate
      for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_clr
         assign clr_req[k] = hit & we & ~wdata[k];
      end
      if (RSVD_W > 0) begin : g_rsvd
         assign unused_rsvd_wdata = ^wdata[DATA_W-1:NUM_FLAGS];
         assign rdata = hit ? {{RSVD_W{1'b0}}, flags} : '0;
      end else begin : g_full
         assign unused_rsvd_wdata = 1'b0;
         assign rdata = hit ? flags : '0;
      end
   endgenerate
endmodule

// File: rtl/nrdy_irq_combine.sv
module nrdy_irq_combine #(
   parameter int unsigned NUM_FLAGS = 7
) (
   input  logic [NUM_FLAGS-1:0] flags,
   input  logic [NUM_FLAGS-1:0] enables,
   output logic                 irq
);
   logic [NUM_FLAGS-1:0] live;

   generate
      for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_and
         assign live[k] = flags[k] & enables[k];
      end
   endgenerate

   assign irq = |live;
endmodule

// File: rtl/nrdy_irq_status.sv
module nrdy_irq_status
   import nrdy_pkg::*;
#(
   parameter int unsigned NUM_PIPES  = NRDY_DEF_PIPES,
   parameter int unsigned DATA_W     = NRDY_DEF_DATA_W,
   parameter int unsigned ADDR_W     = NRDY_DEF_ADDR_W,
   parameter logic [ADDR_W-1:0] REG_OFFSET = NRDY_DEF_OFFSET,
   parameter nrdy_prio_e  PRIO       = PRIO_EVENT_WINS
) (
   input  logic                 clk,
   input  logic                 hw_rst_n,
   input  logic                 sw_rst,
   input  logic                 bus_rst,
   input  logic [NUM_PIPES-1:0] evt_i,
   input  logic [NUM_PIPES-1:0] irq_en_i,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic                 bus_we,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 irq_o
);
   logic [NUM_PIPES-1:0] flags_q;
   logic [NUM_PIPES-1:0] clr_req;
   logic                 unused_bus_rst;

   // The bus reset is deliberately not wired to the flags.
   assign unused_bus_rst = bus_rst;

   generate
      if (NUM_PIPES < 1 || NUM_PIPES > DATA_W) begin : g_bad_pipes
         $error("nrdy_irq_status: NUM_PIPES must be 1..DATA_W");
      end
      if (REG_OFFSET[0] != 1'b0) begin : g_bad_offset
         $error("nrdy_irq_status: REG_OFFSET must be half-word aligned");
      end
   endgenerate

   nrdy_reg_decode #(
      .NUM_FLAGS (NUM_PIPES),
      .DATA_W    (DATA_W),
      .ADDR_W    (ADDR_W),
      .REG_OFFSET(REG_OFFSET)
   ) u_decode (
      .addr   (bus_addr),
      .we     (bus_we),
      .wdata  (bus_wdata),
      .flags  (flags_q),
      .clr_req(clr_req),
      .rdata  (bus_rdata)
   );

   generate
      for (genvar k = 0; k < NUM_PIPES; k++) begin : g_flag
         nrdy_flag_req_t req;
         assign req.set = evt_i[k];
         assign req.clr = clr_req[k];
         nrdy_flag_cell #(.PRIO(PRIO)) u_cell (
            .clk     (clk),
            .hw_rst_n(hw_rst_n),
            .sw_rst  (sw_rst),
            .req     (req),
            .flag_q  (flags_q[k])
         );
      end
   endgenerate

   nrdy_irq_combine #(.NUM_FLAGS(NUM_PIPES)) u_irq (
      .flags  (flags_q),
      .enables(irq_en_i),
      .irq    (irq_o)
   );
endmodule

// File: rtl/nrdy_irq_status_chk.sv
module nrdy_irq_status_chk #(
   parameter int unsigned NUM_PIPES = 7,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] REG_OFFSET = 8'h68
) (
   input logic                 clk,
   input logic                 hw_rst_n,
   input logic                 sw_rst,
   input logic [NUM_PIPES-1:0] evt_i,
   input logic [NUM_PIPES-1:0] irq_en_i,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic                 bus_we,
   input logic [DATA_W-1:0]    bus_wdata,
   input logic [DATA_W-1:0]    bus_rdata,
   input logic                 irq_o,
   input logic [NUM_PIPES-1:0] flags
);
   logic wr_hit;
   assign wr_hit = bus_we && (bus_addr == REG_OFFSET);

   assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!hw_rst_n)
      !sw_rst |=> ((flags & $past(evt_i)) == $past(evt_i)));

   assert_no_spurious_set_R2: assert property (@(posedge clk) disable iff (!hw_rst_n)
      !sw_rst |=> ((flags & ~($past(flags) | $past(evt_i))) == '0));

   assert_zero_clears_R2: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (wr_hit && !sw_rst) |=>
         ((flags & ~$past(bus_wdata[NUM_PIPES-1:0]) & ~$past(evt_i)) == '0));

   assert_hold_R4_R8: assert property (@(posedge clk) disable iff (!hw_rst_n)
      (!sw_rst && evt_i == '0 && !wr_hit) |=> $stable(flags));

   assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (!hw_rst_n)
      bus_rdata[DATA_W-1:NUM_PIPES] == '0);

   assert_swrst_R7: assert property (@(posedge clk) disable iff (!hw_rst_n)
      sw_rst |=> (flags == '0));

   assert_irq_R9: assert property (@(posedge clk) disable iff (!hw_rst_n)
      irq_o == |(flags & irq_en_i));
endmodule

bind nrdy_irq_status nrdy_irq_status_chk #(
   .NUM_PIPES (NUM_PIPES),
   .DATA_W    (DATA_W),
   .ADDR_W    (ADDR_W),
   .REG_OFFSET(REG_OFFSET)
) u_chk (
   .clk      (clk),
   .hw_rst_n (hw_rst_n),
   .sw_rst   (sw_rst),
   .evt_i    (evt_i),
   .irq_en_i (irq_en_i),
   .bus_addr (bus_addr),
   .bus_we   (bus_we),
   .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata),
   .irq_o    (irq_o),
   .flags    (flags_q)
);

// File: tb/nrdy_irq_status_tb_top.sv
module nrdy_irq_status_tb_top;
   localparam time CLK_PER = 20ns;
   localparam int  NVEC    = 12;
   localparam logic [7:0] REG = 8'h68;

   logic        clk = 1'b0;
   logic        hw_rst_n = 1'b0;
   logic        sw_rst = 1'b0;
   logic        bus_rst = 1'b0;
   logic [6:0]  evt_i = '0;
   logic [6:0]  irq_en_i = 7'h7F;
   logic [7:0]  bus_addr = REG;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   nrdy_irq_status dut_i (
      .clk(clk), .hw_rst_n(hw_rst_n), .sw_rst(sw_rst), .bus_rst(bus_rst),
      .evt_i(evt_i), .irq_en_i(irq_en_i), .bus_addr(bus_addr),
      .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_o(irq_o)
   );

   // {evt[7], we[1], wdata[16], en[7], exp_rdata[16], exp_irq[1]}
   localparam logic [47:0] VECS [NVEC] = '{
      {7'h01, 1'b0, 16'h0000, 7'h7F, 16'h0001, 1'b1},  // R1 control pipe
      {7'h40, 1'b0, 16'h0000, 7'h7F, 16'h0041, 1'b1},  // R1 pipe 6
      {7'h00, 1'b1, 16'hFFFF, 7'h7F, 16'h0041, 1'b1},  // R2 ones ignored
      {7'h00, 1'b1, 16'hFFFE, 7'h7F, 16'h0040, 1'b1},  // R2 clear bit 0
      {7'h02, 1'b1, 16'hFFBF, 7'h7F, 16'h0002, 1'b1},  // R2 clear 6, set 1
      {7'h04, 1'b1, 16'hFFFB, 7'h7F, 16'h0006, 1'b1},  // R5 event beats clear
      {7'h00, 1'b0, 16'h0000, 7'h00, 16'h0006, 1'b0},  // R9 all masked
      {7'h00, 1'b0, 16'h0000, 7'h04, 16'h0006, 1'b1},  // R9 pipe 2 enabled
      {7'h00, 1'b0, 16'h0000, 7'h01, 16'h0006, 1'b0},  // R9 non-matching enable
      {7'h00, 1'b1, 16'h0000, 7'h7F, 16'h0000, 1'b0},  // R2 clear all
      {7'h7F, 1'b0, 16'h0000, 7'h7F, 16'h007F, 1'b1},  // R1 R3 all pipes
      {7'h00, 1'b1, 16'hFF80, 7'h7F, 16'h0000, 1'b0}   // R10 reserved ones
   };

   task automatic check(string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Drive at a falling edge, let one rising edge act, check at the next falling edge.
   task automatic step(logic [6:0] evt, logic we, logic [15:0] wd);
      evt_i = evt; bus_we = we; bus_wdata = wd;
      @(negedge clk);
      evt_i = '0; bus_we = 1'b0; bus_wdata = '0;
   endtask

   initial begin : watchdog
      #(CLK_PER * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(negedge clk);
      check("R6 reset rdata", bus_rdata, 16'h0000);
      check("R6 reset irq", {15'd0, irq_o}, 16'h0000);
      hw_rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         irq_en_i = VECS[i][23:17];
         step(VECS[i][47:41], VECS[i][40], VECS[i][39:24]);
         check($sformatf("R3 vec%0d rdata", i), bus_rdata, VECS[i][16:1]);
         check($sformatf("R9 vec%0d irq", i), {15'd0, irq_o}, {15'd0, VECS[i][0]});
      end

      // R8: bus reset with all flags set
      irq_en_i = 7'h7F;
      step(7'h7F, 1'b0, 16'h0000);
      bus_rst = 1'b1;
      @(negedge clk);
      bus_rst = 1'b0;
      @(negedge clk);
      check("R8 bus reset keeps flags", bus_rdata, 16'h007F);

      // R4: other address reads zero, writes there ignored
      bus_addr = 8'h6A;
      #1 check("R4 other addr read", bus_rdata, 16'h0000);
      step(7'h00, 1'b1, 16'h0000);
      bus_addr = 8'h66;
      step(7'h00, 1'b1, 16'h0000);
      bus_addr = REG;
      #1 check("R4 other addr write ignored", bus_rdata, 16'h007F);

      // R10: reserved ones written, flags cleared by the zeros, reserved still zero
      @(negedge clk);
      step(7'h00, 1'b1, 16'hFFA0);
      check("R10 reserved bits", bus_rdata, 16'h0020);

      // R7: software reset beats a simultaneous event
      sw_rst = 1'b1;
      step(7'h7F, 1'b0, 16'h0000);
      sw_rst = 1'b0;
      check("R7 sw reset", bus_rdata, 16'h0000);
      check("R7 irq after sw reset", {15'd0, irq_o}, 16'h0000);

      // R1: flag is sticky over several idle cycles
      step(7'h08, 1'b0, 16'h0000);
      repeat (3) @(negedge clk);
      check("R1 sticky", bus_rdata, 16'h0008);

      // R6: asynchronous hardware reset mid-run
      hw_rst_n = 1'b0;
      #1 check("R6 async hw reset", bus_rdata, 16'h0000);
      @(negedge clk);
      hw_rst_n = 1'b1;
      @(negedge clk);
      check("R6 after release", bus_rdata, 16'h0000);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule